// File: doc/BRIEF.md
# I/O Port Status and Control Register Block

This block sits on the I/O bus of a small 8-bit computer and answers a handful of fixed port addresses. CPU writes to three ports either latch control bits (a five-bit control group and a request-to-send bit) or emit a one-cycle load strobe with the byte toward a serial transmitter. CPU reads return either the raw state of eight sense switches or a status byte.

An asynchronous, active-low keyboard-ready pulse is brought into the clock domain and turned into a sticky flag. The flag shows active-low in the status byte and stays set until the keyboard data port is read or power-on clear is applied. An active-low parallel-device-ready input also appears in the status byte. Read data is combinational and idles at 0xFF. The read and write strobes are sampled on the rising clock edge.

Top module: `iox_port_block`

## Requirements
- R1: A read of port 0xFF returns `sense_sw_n` unchanged on `io_rdata`, so a closed switch (input 0) reads as 0 and an open switch reads as 1.
- R2: A write to port 0xFA loads `io_wdata[7:3]` into `ctrl_out[4:0]` (`ctrl_out[i]` = `io_wdata[i+3]`). The new value shows in the cycle after the write edge. `par_in_en` equals `ctrl_out[0]` (data bit 3) and `par_dev_sel` equals `ctrl_out[1]` (data bit 4).
- R3: While `poc` is high, `ctrl_out`, `par_in_en`, `par_dev_sel`, `rts`, `tx_load` and the keyboard flag all go to 0 on the clock edge.
- R4: A write to port 0xF8 loads `io_wdata[4]` into `rts`, and `rts` keeps that value until the next write to 0xF8 or power-on clear.
- R5: A falling edge on `kbd_rdy_n` sets the keyboard flag on the third rising clock edge after the input goes low (two synchronizer stages plus the flag register). The flag stays set after the input returns high, and a rising edge never sets it.
- R6: A read of port 0xFA returns a status byte. Bit 0 is the inverse of the keyboard flag (0 means a key is ready), bit 2 is `pdev_rdy_n` as applied, and all other bits are 1.
- R7: A read of port 0xFC clears the keyboard flag on that clock edge. If a new keyboard falling edge is detected on the same edge, the flag is set instead.
- R8: A write to port 0xF9 raises `tx_load` for exactly one cycle, in the cycle after the first write edge, and `tx_data` carries the written byte during that cycle. A write strobe held for several cycles gives only one pulse.
- R9: `io_rdata` is 0xFF whenever `io_rd` is low, or when the address is anything other than 0xFF or 0xFA (port 0xFC included).
- R10: Writes to any other address, and reads of any address, leave `ctrl_out`, `rts` and `tx_load` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (at least 6 MHz for the keyboard capture bound) |
| poc | input | 1 | Power-on clear, synchronous, active high |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | CPU write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | Read data, 0xFF when not driven |
| sense_sw_n | input | 8 | Sense switch inputs, 0 = closed |
| kbd_rdy_n | input | 1 | Asynchronous keyboard-ready pulse, active low |
| pdev_rdy_n | input | 1 | Parallel device ready, active low |
| ctrl_out | output | 5 | Latched control bits |
| par_in_en | output | 1 | Parallel input enable |
| par_dev_sel | output | 1 | Parallel device select |
| rts | output | 1 | Request-to-send output |
| tx_load | output | 1 | One-cycle load strobe toward the serial transmitter |
| tx_data | output | 8 | Byte that goes with `tx_load` |

## Verification
All 256 sense-switch patterns are read back, which catches inverted, swapped or stuck bits. All 256 write bytes go to the control and request-to-send ports, which shows that exactly the right data bits are taken and that each port leaves the other's state alone. A read sweep over every address, with both parallel-ready levels, separates the decoded ports from the idle value. Keyboard pulses are sampled one edge before and at the expected capture edge, then checked again after release, after a clearing read, and with a clear that lands on the same edge as a new capture, which tells set priority and stickiness apart from plain level following.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // fixed port map
    localparam addr_t PORT_RTS    = 8'hF8;
    localparam addr_t PORT_TX     = 8'hF9;
    localparam addr_t PORT_CTL    = 8'hFA;   // write: control, read: status
    localparam addr_t PORT_KBD    = 8'hFC;
    localparam addr_t PORT_SENSE  = 8'hFF;

    // control group field
    localparam int CTRL_LSB = 3;
    localparam int CTRL_W   = DATA_W - CTRL_LSB;
    localparam int RTS_BIT  = 4;

    // status byte bit positions
    localparam int STAT_KBD_BIT  = 0;
    localparam int STAT_PDEV_BIT = 2;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        logic wr_rts;
        logic wr_tx;
        logic wr_ctl;
        logic rd_kbd;
        logic rd_status;
        logic rd_sense;
    } port_hit_t;

    function automatic data_t build_status(input logic kbd_flag, input logic pdev_n);
        data_t s;
        s = '1;
        s[STAT_KBD_BIT]  = ~kbd_flag;
        s[STAT_PDEV_BIT] = pdev_n;
        return s;
    endfunction

endpackage

// File: rtl/iox_port_decode.sv
module iox_port_decode
    import iox_pkg::*;
(
    input  addr_t     addr,
    input  logic      rd,
    input  logic      wr,
    output port_hit_t hits
);

    always_comb begin
        hits           = '0;
        hits.wr_rts    = wr && (addr == PORT_RTS);
        hits.wr_tx     = wr && (addr == PORT_TX);
        hits.wr_ctl    = wr && (addr == PORT_CTL);
        hits.rd_kbd    = rd && (addr == PORT_KBD);
        hits.rd_status = rd && (addr == PORT_CTL);
        hits.rd_sense  = rd && (addr == PORT_SENSE);
    end

endmodule

// File: rtl/iox_hold_reg.sv
module iox_hold_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R10

endmodule

// File: rtl/iox_kbd_capture.sv
module iox_kbd_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kbd_n,
    input  logic clr,
    output logic flag
);

    localparam int SN = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SN-1:0] sync_q;
    logic          last_q;
    logic          fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SN-2:0], kbd_n};
            last_q <= sync_q[SN-1];
        end
    end

    assign fall = last_q && !sync_q[SN-1];

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (fall) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    AST_KBD_SET:    assert property (@(posedge clk) disable iff (rst)
        fall |=> flag); // R5
    AST_KBD_CLEAR:  assert property (@(posedge clk) disable iff (rst)
        (clr && !fall) |=> !flag); // R7
    AST_KBD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R5

endmodule

// File: rtl/iox_tx_strobe.sv
module iox_tx_strobe
    import iox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  data_t wdata,
    output logic  load,
    output data_t data
);

    logic  hit_q;
    logic  first;

    assign first = hit && !hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            load  <= 1'b0;
            data  <= '0;
        end else begin
            hit_q <= hit;
            load  <= first;
            if (first) data <= wdata;
        end
    end

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load |=> !load); // R8
    AST_TX_CAUSE:  assert property (@(posedge clk) disable iff (rst)
        load |-> $past(hit)); // R8

endmodule

// File: rtl/iox_port_block.sv
module iox_port_block
    import iox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       poc,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    input  logic       io_rd,
    input  logic       io_wr,
    output logic [7:0] io_rdata,
    input  logic [7:0] sense_sw_n,
    input  logic       kbd_rdy_n,
    input  logic       pdev_rdy_n,
    output logic [4:0] ctrl_out,
    output logic       par_in_en,
    output logic       par_dev_sel,
    output logic       rts,
    output logic       tx_load,
    output logic [7:0] tx_data
);

    port_hit_t hits;
    ctrl_t     ctrl_q;
    logic      kbd_flag;

    iox_port_decode u_dec (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .hits (hits)
    );

    iox_hold_reg #(.W(CTRL_W)) u_ctrl (
        .clk  (clk),
        .rst  (poc),
        .load (hits.wr_ctl),
        .d    (io_wdata[DATA_W-1:CTRL_LSB]),
        .q    (ctrl_q)
    );

    iox_hold_reg #(.W(1)) u_rts (
        .clk  (clk),
        .rst  (poc),
        .load (hits.wr_rts),
        .d    (io_wdata[RTS_BIT]),
        .q    (rts)
    );

    iox_kbd_capture #(.SYNC_STAGES(SYNC_STAGES)) u_kbd (
        .clk   (clk),
        .rst   (poc),
        .kbd_n (kbd_rdy_n),
        .clr   (hits.rd_kbd),
        .flag  (kbd_flag)
    );

    iox_tx_strobe u_tx (
        .clk   (clk),
        .rst   (poc),
        .hit   (hits.wr_tx),
        .wdata (io_wdata),
        .load  (tx_load),
        .data  (tx_data)
    );

    assign ctrl_out    = ctrl_q;
    assign par_in_en   = ctrl_q[0];
    assign par_dev_sel = ctrl_q[1];

    always_comb begin
        io_rdata = '1;
        if (hits.rd_sense)       io_rdata = sense_sw_n;
        else if (hits.rd_status) io_rdata = build_status(kbd_flag, pdev_rdy_n);
    end

    AST_RDATA_IDLE: assert property (@(posedge clk)
        !io_rd |-> (io_rdata == 8'hFF)); // R9
    AST_RTS_HOLD:   assert property (@(posedge clk) disable iff (poc)
        !(io_wr && io_addr == PORT_RTS) |=> $stable(rts)); // R4
    AST_CTRL_LOAD:  assert property (@(posedge clk) disable iff (poc)
        (io_wr && io_addr == PORT_CTL) |=> (ctrl_out == $past(io_wdata[7:3]))); // R2
    AST_POC_CLEAR:  assert property (@(posedge clk)
        poc |=> (ctrl_out == '0 && !rts && !tx_load)); // R3

endmodule

// File: tb/iox_port_block_tb.sv
module iox_port_block_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       poc = 1'b1;
    logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] sense_sw_n = 8'h5A;
    logic       kbd_rdy_n = 1'b1, pdev_rdy_n = 1'b1;
    logic [4:0] ctrl_out;
    logic       par_in_en, par_dev_sel, rts, tx_load;
    logic [7:0] tx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iox_port_block dut_i (
        .clk(clk), .poc(poc), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .sense_sw_n(sense_sw_n), .kbd_rdy_n(kbd_rdy_n), .pdev_rdy_n(pdev_rdy_n),
        .ctrl_out(ctrl_out), .par_in_en(par_in_en), .par_dev_sel(par_dev_sel),
        .rts(rts), .tx_load(tx_load), .tx_data(tx_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_status(input logic flag, input logic pd);
        logic [7:0] s;
        s = 8'hFF;
        s[0] = ~flag;
        s[2] = pd;
        return s;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        logic [4:0] e_ctrl;
        logic       e_rts;
        int         pulses;

        repeat (3) @(negedge clk);
        poc = 1'b0;
        @(negedge clk);

        // R3: reset state
        chk("R3 ctrl", ctrl_out, 0);
        chk("R3 rts", rts, 0);
        chk("R3 tx_load", tx_load, 0);
        rd_port(8'hFA, rv);
        chk("R3 flag clear in status", rv, 8'hFF);

        // R1: every switch pattern
        for (int i = 0; i < 256; i++) begin
            sense_sw_n = i[7:0];
            rd_port(8'hFF, rv);
            chk("R1 sense read", rv, i);
        end

        // R2 and R10: every byte to the control port, rts must not move
        e_rts = 1'b0;
        for (int i = 0; i < 256; i++) begin
            wr_port(8'hFA, i[7:0]);
            e_ctrl = i[7:3];
            chk("R2 ctrl_out", ctrl_out, e_ctrl);
            chk("R2 par_in_en", par_in_en, i[3]);
            chk("R2 par_dev_sel", par_dev_sel, i[4]);
            chk("R10 rts untouched by ctrl write", rts, e_rts);
        end

        // R4 and R10: every byte to the rts port, ctrl must not move
        for (int i = 0; i < 256; i++) begin
            wr_port(8'hF8, i[7:0]);
            e_rts = i[4];
            chk("R4 rts", rts, e_rts);
            chk("R10 ctrl untouched by rts write", ctrl_out, e_ctrl);
            chk("R10 no tx_load", tx_load, 0);
        end

        // R10: other ports and reads leave latches alone
        for (int a = 0; a < 256; a++) begin
            if (a != 8'hF8 && a != 8'hF9 && a != 8'hFA) begin
                wr_port(a[7:0], 8'h00);
                chk("R10 ctrl stable", ctrl_out, e_ctrl);
                chk("R10 rts stable", rts, e_rts);
                chk("R10 tx_load quiet", tx_load, 0);
            end
        end

        // R6 and R9: read sweep over all addresses, both pdev levels
        for (int pd = 0; pd < 2; pd++) begin
            pdev_rdy_n = pd[0];
            sense_sw_n = 8'h3C;
            for (int a = 0; a < 256; a++) begin
                rd_port(a[7:0], rv);
                if (a == 8'hFF)      chk("R1 sweep", rv, 8'h3C);
                else if (a == 8'hFA) chk("R6 status", rv, exp_status(1'b0, pd[0]));
                else                 chk("R9 undecoded read", rv, 8'hFF);
            end
            chk("R10 ctrl after reads", ctrl_out, e_ctrl);
        end
        @(negedge clk);
        #1 chk("R9 idle rdata", io_rdata, 8'hFF);

        // R8: single write, pulse with data
        for (int k = 0; k < 4; k++) begin
            wr_port(8'hF9, 8'h11 * (k + 3));
            chk("R8 tx_load pulse", tx_load, 1);
            chk("R8 tx_data", tx_data, 8'h11 * (k + 3));
            @(negedge clk);
            chk("R8 tx_load single", tx_load, 0);
        end
        // R8: held write gives one pulse
        @(negedge clk);
        io_addr = 8'hF9; io_wdata = 8'hA5; io_wr = 1'b1;
        pulses = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (tx_load) pulses++;
        end
        io_wr = 1'b0;
        @(negedge clk);
        if (tx_load) pulses++;
        chk("R8 held write pulses", pulses, 1);
        chk("R8 held data", tx_data, 8'hA5);

        // R5: capture timing
        pdev_rdy_n = 1'b1;
        @(negedge clk);
        kbd_rdy_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        io_addr = 8'hFA; io_rd = 1'b1;
        #1 chk("R5 not yet after two edges", io_rdata[0], 1);
        @(negedge clk);
        #1 chk("R5 set on third edge", io_rdata[0], 0);
        io_rd = 1'b0;
        repeat (6) @(negedge clk);
        kbd_rdy_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_port(8'hFA, rv);
        chk("R5 sticky after release", rv, exp_status(1'b1, 1'b1));
        rd_port(8'hFA, rv);
        chk("R6 status read does not clear", rv[0], 0);

        // R7: keyboard data read clears, reads as idle data
        rd_port(8'hFC, rv);
        chk("R9 kbd port reads FF", rv, 8'hFF);
        rd_port(8'hFA, rv);
        chk("R7 cleared by kbd read", rv[0], 1);

        // R7: clear on the same edge as a new capture, set wins
        @(negedge clk);
        kbd_rdy_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        io_addr = 8'hFC; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        repeat (4) @(negedge clk);
        kbd_rdy_n = 1'b1;
        rd_port(8'hFA, rv);
        chk("R7 set wins over clear", rv[0], 0);

        // R3: power-on clear wipes everything
        wr_port(8'hFA, 8'hFF);
        wr_port(8'hF8, 8'h10);
        @(negedge clk);
        poc = 1'b1;
        @(negedge clk);
        chk("R3 ctrl cleared", ctrl_out, 0);
        chk("R3 rts cleared", rts, 0);
        chk("R3 par bits cleared", {par_in_en, par_dev_sel}, 0);
        poc = 1'b0;
        rd_port(8'hFA, rv);
        chk("R3 flag cleared", rv, 8'hFF);

        finish_run();
    end

endmodule